// File: doc/BRIEF.md
# Legacy Memory Region Decoder

This block is the address classifier of a bus interface. It holds a small bank of four 32-bit control registers in a 256-byte window and, for every memory or I/O access presented on its classification port, decides combinationally where the access goes: system DRAM, the graphics pipeline, or nowhere. It also reports whether the access may be cached, produces the address with bit 20 masked when legacy wrap-around is active, and raises a system management interrupt request for trapped display I/O ports.

Software programs the registers through a simple single-cycle read/write port. A register write lands on the clock edge and steers every access that follows. Register accesses that come from the PCI side are refused unless the block's PCI-access enable is set. DRAM membership uses a top-of-memory limit kept at 128 KB granularity. The two 32 KB legacy video windows at B0000h and B8000h can each be handed to the graphics pipeline, and they are then never cacheable. Reads and writes are classified the same way, so the access direction is not an input.

Top module: `legacy_region_decoder`

## Requirements
- R1: After reset, offset 00h reads 0FFFFFFFh (limit field 7FFh) and offsets 04h, 08h and 0Ch read 00000000h.
- R2: Only offsets 00h, 04h, 08h and 0Ch of the window hold registers. Any other offset reads 0, and a write to it changes no register.
- R3: In the limit register (00h), bits 31:28 read 0, bits 16:0 read 1, and only bits 27:17 are stored. In the map register (04h), only bits 28:24 and 22:15 are stored and the rest read 0. Registers 08h and 0Ch store all 32 bits.
- R4: A register access with reg_from_pci=1 while map bit 22 is 0 asserts reg_err, reads 0 and changes no register. With bit 22 set, such accesses work normally.
- R5: A memory access that is not graphics-steered is DRAM when its (masked) address is at most {4'h0, limit[27:17], 17'h1FFFF}. Otherwise it is unclaimed (dram=0, gfx=0).
- R6: Map bit 20 steers B0000h–B7FFFh and map bit 28 steers B8000h–BFFFFh to graphics. A steered access has gfx=1, dram=0 and cacheable=0, whatever the state of control bit 18 or 26.
- R7: A DRAM access in B0000h–B7FFFh that is not steered has cacheable equal to map bit 18. In B8000h–BFFFFh the same rule uses map bit 26. Any other DRAM access is cacheable. A non-DRAM access is never cacheable.
- R8: With map bit 21 set and acc_smi_mode=0, address bit 20 of a memory access is forced to 0 on acc_addr_out, and the decode uses that address. In SMI mode, and for I/O, acc_addr_out equals acc_addr.
- R9: With map bit 15 set, an I/O access to port 3D0h–3DFh (all higher address bits zero) asserts acc_smi_req. Memory accesses never assert it.
- R10: An I/O access has dram, gfx and cacheable all 0.
- R11: A register write made on one clock edge changes the read data and the classification seen by the accesses that follow that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read enable |
| reg_addr | input | 8 | Byte offset within the window |
| reg_wdata | input | 32 | Write data |
| reg_from_pci | input | 1 | Access originates from the PCI slave |
| reg_rdata | output | 32 | Read data (combinational) |
| reg_err | output | 1 | PCI-originated access refused |
| acc_addr | input | 32 | Access address |
| acc_is_io | input | 1 | 1 = I/O access, 0 = memory access |
| acc_smi_mode | input | 1 | Access made in SMI mode |
| acc_addr_out | output | 32 | Address after A20 masking |
| acc_dram | output | 1 | Access targets system DRAM |
| acc_gfx | output | 1 | Access steered to the graphics pipeline |
| acc_cacheable | output | 1 | Access may be cached |
| acc_smi_req | output | 1 | SMI request for a trapped I/O port |

## Verification
Read data, reg_err and every classification output settle in the same cycle as their inputs, with no register in the path. The bench therefore drives each stimulus just after a falling edge and samples 1 ns later, before the next rising edge. A register write takes effect only at the rising edge that samples it. The bench updates its own copy of the registers at that edge, so every read or classification made after the write is compared against the new contents.

// File: rtl/lrd_pkg.sv
`timescale 1ns/1ps
package lrd_pkg;
   localparam int DATA_W   = 32;
   localparam int NUM_REGS = 4;
   localparam int IDX_W    = $clog2(NUM_REGS);

   typedef enum logic [IDX_W-1:0] {
      IDX_LIMIT = 2'd0,
      IDX_MAP   = 2'd1,
      IDX_AUX0  = 2'd2,
      IDX_AUX1  = 2'd3
   } reg_idx_e;

   // map register bit positions (behavioural)
   localparam int MAP_TRAP_EN  = 15;
   localparam int MAP_A20_EN   = 21;
   localparam int MAP_PCI_EN   = 22;
   localparam int MAP_WIN_BASE = 16; // window g: ctl at 16+8g, enable at 20+8g
   localparam int CTL_CACHE    = 2;

   function automatic logic [DATA_W-1:0] store_mask(input int i);
      case (i)
         0:       return 32'h0FFE_0000;
         1:       return 32'h1F7F_8000;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

   function automatic logic [DATA_W-1:0] fixed_ones(input int i);
      return (i == 0) ? 32'h0001_FFFF : 32'h0000_0000;
   endfunction

   function automatic logic [DATA_W-1:0] reset_store(input int i);
      return (i == 0) ? 32'h0FFE_0000 : 32'h0000_0000;
   endfunction
endpackage

// File: rtl/lrd_regfile.sv
`timescale 1ns/1ps
module lrd_regfile
   import lrd_pkg::*;
#(
   parameter int WIN_W = 8
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic                              rd_en,
   input  logic [WIN_W-1:0]                  addr,
   input  logic [DATA_W-1:0]                 wdata,
   input  logic                              from_pci,
   output logic [DATA_W-1:0]                 rdata,
   output logic                              err,
   output logic [NUM_REGS-1:0][DATA_W-1:0]   regs_o
);
   localparam int LOW_W = IDX_W + 2;

   logic             hit;
   logic [IDX_W-1:0] idx;
   logic             pci_block;

   assign idx       = addr[LOW_W-1:2];
   assign hit       = (addr[1:0] == 2'b00) &&
                      (addr[WIN_W-1:LOW_W] == '0);
   assign pci_block = from_pci & ~regs_o[IDX_MAP][MAP_PCI_EN];

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      logic [DATA_W-1:0] store_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            store_q <= reset_store(g);
         else if (wr_en && hit && !pci_block && (idx == IDX_W'(g)))
            store_q <= wdata & store_mask(g);
      end
      assign regs_o[g] = (store_q & store_mask(g)) | fixed_ones(g);
   end

   assign rdata = (rd_en && hit && !pci_block) ? regs_o[idx] : '0;
   assign err   = (wr_en | rd_en) & pci_block;
endmodule

// File: rtl/lrd_classify.sv
`timescale 1ns/1ps
module lrd_classify
   import lrd_pkg::*;
#(
   parameter int          ADDR_W     = 32,
   parameter int          A20_BIT    = 20,
   parameter int          WIN_LOG2   = 15,
   parameter int          WIN_FIRST  = 22,
   parameter int          NUM_WIN    = 2,
   parameter int          TRAP_BASE  = 32'h3D0
) (
   input  logic [DATA_W-1:0] limit_reg,
   input  logic [DATA_W-1:0] map_reg,
   input  logic [ADDR_W-1:0] addr,
   input  logic              is_io,
   input  logic              smi_mode,
   output logic [ADDR_W-1:0] addr_out,
   output logic              dram,
   output logic              gfx,
   output logic              cacheable,
   output logic              smi_req
);
   localparam int TAG_W = ADDR_W - WIN_LOG2;
   localparam int PORT_W = ADDR_W - 4;

   logic [ADDR_W-1:0]  masked;
   logic [ADDR_W-1:0]  top_addr;
   logic [NUM_WIN-1:0] in_win;
   logic [NUM_WIN-1:0] steer;
   logic [NUM_WIN-1:0] win_cache;
   logic               below_top;

   always_comb begin
      masked = addr;
      if (!is_io && !smi_mode && map_reg[MAP_A20_EN])
         masked[A20_BIT] = 1'b0;
   end

   assign top_addr  = ADDR_W'(limit_reg[27:0]);
   assign below_top = (masked <= top_addr);

   for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
      assign in_win[g]    = !is_io &&
                            (masked[ADDR_W-1:WIN_LOG2] == TAG_W'(WIN_FIRST + g));
      assign steer[g]     = in_win[g] & map_reg[MAP_WIN_BASE + 8*g + 4];
      assign win_cache[g] = in_win[g] & map_reg[MAP_WIN_BASE + 8*g + CTL_CACHE];
   end

   assign gfx       = |steer;
   assign dram      = !is_io && !gfx && below_top;
   assign cacheable = dram && ((in_win == '0) || (|win_cache));
   assign smi_req   = is_io && map_reg[MAP_TRAP_EN] &&
                      (addr[ADDR_W-1:4] == PORT_W'(TRAP_BASE >> 4));
   assign addr_out  = masked;
endmodule

// File: rtl/legacy_region_decoder.sv
`timescale 1ns/1ps
module legacy_region_decoder
   import lrd_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int WIN_W     = 8,
   parameter int A20_BIT   = 20,
   parameter int TRAP_BASE = 32'h3D0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [WIN_W-1:0]  reg_addr,
   input  logic [31:0]       reg_wdata,
   input  logic              reg_from_pci,
   output logic [31:0]       reg_rdata,
   output logic              reg_err,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_is_io,
   input  logic              acc_smi_mode,
   output logic [ADDR_W-1:0] acc_addr_out,
   output logic              acc_dram,
   output logic              acc_gfx,
   output logic              acc_cacheable,
   output logic              acc_smi_req
);
   if (ADDR_W < 28 || ADDR_W > 32) begin : g_bad_addr
      $error("ADDR_W must lie between 28 and 32");
   end
   if (WIN_W < IDX_W + 3) begin : g_bad_win
      $error("WIN_W too small for the register window");
   end
   if (TRAP_BASE % 16 != 0) begin : g_bad_trap
      $error("TRAP_BASE must be 16-port aligned");
   end
   if (A20_BIT >= ADDR_W) begin : g_bad_a20
      $error("A20_BIT outside the address");
   end

   logic [NUM_REGS-1:0][DATA_W-1:0] regs;

   lrd_regfile #(.WIN_W(WIN_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr),
      .rd_en    (reg_rd),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .from_pci (reg_from_pci),
      .rdata    (reg_rdata),
      .err      (reg_err),
      .regs_o   (regs)
   );

   lrd_classify #(
      .ADDR_W    (ADDR_W),
      .A20_BIT   (A20_BIT),
      .TRAP_BASE (TRAP_BASE)
   ) u_cls (
      .limit_reg (regs[IDX_LIMIT]),
      .map_reg   (regs[IDX_MAP]),
      .addr      (acc_addr),
      .is_io     (acc_is_io),
      .smi_mode  (acc_smi_mode),
      .addr_out  (acc_addr_out),
      .dram      (acc_dram),
      .gfx       (acc_gfx),
      .cacheable (acc_cacheable),
      .smi_req   (acc_smi_req)
   );
endmodule

// File: rtl/lrd_checker.sv
`timescale 1ns/1ps
module lrd_checker #(
   parameter int ADDR_W = 32,
   parameter int WIN_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [WIN_W-1:0]  reg_addr,
   input logic [31:0]       reg_wdata,
   input logic              reg_from_pci,
   input logic [31:0]       reg_rdata,
   input logic              reg_err,
   input logic [ADDR_W-1:0] acc_addr,
   input logic              acc_is_io,
   input logic              acc_smi_mode,
   input logic [ADDR_W-1:0] acc_addr_out,
   input logic              acc_dram,
   input logic              acc_gfx,
   input logic              acc_cacheable,
   input logic              acc_smi_req
);
   a_r10_io_unclaimed: assert property (@(posedge clk) disable iff (!rst_n)
      acc_is_io |-> (!acc_dram && !acc_gfx && !acc_cacheable));

   a_r6_gfx_uncached: assert property (@(posedge clk) disable iff (!rst_n)
      acc_gfx |-> (!acc_cacheable && !acc_dram));

   a_r7_cache_needs_dram: assert property (@(posedge clk) disable iff (!rst_n)
      acc_cacheable |-> acc_dram);

   a_r8_smi_no_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_smi_mode || acc_is_io) |-> (acc_addr_out == acc_addr));

   a_r9_trap_io_only: assert property (@(posedge clk) disable iff (!rst_n)
      acc_smi_req |-> acc_is_io);

   a_r4_refused_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      reg_err |-> (reg_rdata == 32'h0));

   a_r11_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !reg_err && reg_addr == WIN_W'(8'h08)) |=>
      (!(reg_rd && !reg_wr && !reg_err && reg_addr == WIN_W'(8'h08)) ||
       reg_rdata == $past(reg_wdata)));
endmodule

bind legacy_region_decoder lrd_checker #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_chk (.*);

// File: tb/sim_legacy_region_decoder.sv
`timescale 1ns/1ps
module sim_legacy_region_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 0, reg_rd = 0, reg_from_pci = 0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic        reg_err;
   logic [31:0] acc_addr = '0, acc_addr_out;
   logic        acc_is_io = 0, acc_smi_mode = 0;
   logic        acc_dram, acc_gfx, acc_cacheable, acc_smi_req;

   int checks = 0, failures = 0;
   bit done = 0;
   logic [31:0] sh [4];

   always #2 clk = ~clk;

   legacy_region_decoder u0 (.*);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] bench_read(input logic [7:0] a);
      if (a[1:0] != 0 || a[7:4] != 0) return 32'h0;
      return sh[a[3:2]];
   endfunction

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic pci);
      @(negedge clk);
      reg_wr = 1; reg_addr = a; reg_wdata = d; reg_from_pci = pci;
      @(posedge clk);
      if (!(pci && !sh[1][22]) && a[1:0] == 0 && a[7:4] == 0) begin
         case (a[3:2])
            2'd0: sh[0] = (d & 32'h0FFE_0000) | 32'h0001_FFFF;
            2'd1: sh[1] = d & 32'h1F7F_8000;
            default: sh[a[3:2]] = d;
         endcase
      end
      @(negedge clk);
      reg_wr = 0; reg_from_pci = 0;
   endtask

   task automatic rd(input string tag, input logic [7:0] a, input logic pci);
      logic blk;
      @(negedge clk);
      reg_rd = 1; reg_addr = a; reg_from_pci = pci;
      #1;
      blk = pci && !sh[1][22];
      chk(tag, reg_rdata, blk ? 32'h0 : bench_read(a));
      chk({tag, " err"}, {31'h0, reg_err}, {31'h0, blk});
      reg_rd = 0; reg_from_pci = 0;
   endtask

   task automatic acc(input string tag, input logic [31:0] a, input logic io, input logic smi);
      logic [31:0] m, top;
      logic b0, b8, g, d, c, t;
      @(negedge clk);
      acc_addr = a; acc_is_io = io; acc_smi_mode = smi;
      #1;
      m = (!io && !smi && sh[1][21]) ? (a & ~32'h0010_0000) : a;
      top = {4'h0, sh[0][27:17], 17'h1FFFF};
      b0 = !io && m >= 32'hB0000 && m <= 32'hB7FFF;
      b8 = !io && m >= 32'hB8000 && m <= 32'hBFFFF;
      g = (b0 && sh[1][20]) || (b8 && sh[1][28]);
      d = !io && !g && m <= top;
      c = d && (b0 ? sh[1][18] : b8 ? sh[1][26] : 1'b1);
      t = io && sh[1][15] && a >= 32'h3D0 && a <= 32'h3DF;
      chk({tag, " R8 addr"}, acc_addr_out, m);
      chk({tag, " R5 dram"}, {31'h0, acc_dram}, {31'h0, d});
      chk({tag, " R6 gfx"},  {31'h0, acc_gfx}, {31'h0, g});
      chk({tag, " R7 cache"}, {31'h0, acc_cacheable}, {31'h0, c});
      chk({tag, " R9 smi"},  {31'h0, acc_smi_req}, {31'h0, t});
   endtask

   function automatic logic [31:0] pick_addr(input logic io);
      int k = $urandom_range(0, 5);
      if (io) return (k < 3) ? 32'h3D0 + $urandom_range(0, 15) : $urandom_range(0, 32'hFFF);
      case (k)
         0: return 32'hB0000 + $urandom_range(0, 32'hFFFF);
         1: return 32'hB0000 + $urandom_range(0, 32'hFFFF) + 32'h0010_0000;
         2: return {4'h0, sh[0][27:17], 17'h1FFFF} + $urandom_range(0, 2) - 1;
         3: return $urandom_range(0, 32'h1FFFFF);
         default: return $urandom();
      endcase
   endfunction

   initial begin
      void'($urandom(32'd4711));
      sh[0] = 32'h0FFF_FFFF; sh[1] = 0; sh[2] = 0; sh[3] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      // R1 reset values
      rd("R1 limit", 8'h00, 0);
      rd("R1 map",   8'h04, 0);
      rd("R1 aux0",  8'h08, 0);
      rd("R1 aux1",  8'h0C, 0);
      acc("R1 default map", 32'h000B_8000, 0, 0);
      // R3 reserved bits
      wr(8'h00, 32'hFFFF_FFFF, 0); rd("R3 limit ones", 8'h00, 0);
      wr(8'h00, 32'h0000_0000, 0); rd("R3 limit zeros", 8'h00, 0);
      wr(8'h04, 32'hFFFF_FFFF, 0); rd("R3 map ones", 8'h04, 0);
      wr(8'h08, 32'hA5A5_5A5A, 0); rd("R3 aux0 full", 8'h08, 0);
      // R5 minimum top boundary
      acc("R5 at min top", 32'h0001_FFFF, 0, 0);
      acc("R5 above min top", 32'h0002_0000, 0, 0);
      // R2 undefined offsets
      wr(8'h10, 32'h1234_5678, 0); rd("R2 off10", 8'h10, 0);
      wr(8'h02, 32'h0, 0); rd("R2 limit kept", 8'h00, 0);
      rd("R2 offF0", 8'hF0, 0);
      // R4 PCI gating
      wr(8'h04, 32'h0000_0000, 0);
      wr(8'h08, 32'hDEAD_BEEF, 1); rd("R4 blocked read", 8'h08, 1); rd("R4 kept", 8'h08, 0);
      wr(8'h04, 32'h0040_0000, 0);
      wr(8'h08, 32'hDEAD_BEEF, 1); rd("R4 allowed", 8'h08, 1);
      // R11 write seen by next access; R6 steering overrides cache bit
      wr(8'h00, 32'h0FFE_0000, 0);
      wr(8'h04, 32'h1414_0000, 0); acc("R11 R6 b0 steer", 32'h000B_0010, 0, 0);
      acc("R6 b8 steer", 32'h000B_FFFF, 0, 0);
      wr(8'h04, 32'h0404_0000, 0); acc("R7 b0 cache bit", 32'h000B_7FFF, 0, 0);
      acc("R7 b8 cache bit", 32'h000B_8000, 0, 0);
      // R8 A20 masking and SMI exemption
      wr(8'h04, 32'h0030_0000, 0);
      acc("R8 masked", 32'h001B_0000, 0, 0);
      acc("R8 smi exempt", 32'h001B_0000, 0, 1);
      // R9 / R10 trap window edges
      wr(8'h04, 32'h0000_8000, 0);
      acc("R9 R10 3D0", 32'h3D0, 1, 0);
      acc("R9 3DF", 32'h3DF, 1, 0);
      acc("R9 3E0", 32'h3E0, 1, 0);
      acc("R9 3CF", 32'h3CF, 1, 0);
      acc("R9 mem 3D0", 32'h3D0, 0, 0);
      // random mix
      for (int i = 0; i < 400; i++) begin
         int k = $urandom_range(0, 9);
         if (k < 2)      wr(8'h04, $urandom(), 0);
         else if (k < 3) wr(8'h00, $urandom(), 0);
         else if (k < 4) rd("R3 rand read", 8'h00 + 8'($urandom_range(0, 3) * 4), 0);
         else begin
            logic io = ($urandom_range(0, 3) == 0);
            acc("R5 rand", pick_addr(io), io, $urandom_range(0, 1));
         end
      end
      if (!done) begin
         done = 1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #800000;
      if (!done) begin
         done = 1;
         checks++; failures++;
         $display("FAIL watchdog R11 actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule